// File: doc/BRIEF.md
# Write-Count Unlocked Configuration Register Bank

This block holds the setup nibbles of a clock synthesizer. A host writes it in parallel: a 4-bit address, a 4-bit data value and a write strobe. Each real address has a programming register. Each also has an output stage that feeds the rest of the synthesizer through one flat bus.

After reset the output stage shows a fixed set of known values, and it ignores everything the host writes. The block counts every strobe rising edge. This lets the host load the whole set of registers while the synthesizer keeps running on the reset values. Once the threshold count is reached, the output stage opens and stays open. The outputs then show the programming registers, and any later write reaches the bus at the same clock edge that captures it.

The address space has gaps. Two addresses have no storage and one address is reserved. Writes to these three addresses still count toward the threshold, but they never reach the outputs.

Top module: `cfg_unlock_bank`

## Requirements
- R1: While reset is asserted, and after it is released, `cfgOut` equals the parameter `OUT_RST_VAL` (default 52'h0_1234_5678_9ABC) and `unlocked` is 0.
- R2: Before the threshold count of writes (`UNLOCK_WRITES`, default 32) is reached, `cfgOut` keeps its reset value whatever is written.
- R3: `unlocked` rises right after the clock edge that captures the 32nd counted write, and not earlier.
- R4: When the bank unlocks, every output slot shows the last value written to its address, including writes made while the bank was locked.
- R5: After unlock, a write to a real address appears in its output slot right after the clock edge that captures it.
- R6: A write is taken only on a rising edge of `wrStb` that is seen at a clock edge. A strobe held high over several clocks counts as one write.
- R7: Addresses 13 and 14 have no storage. A write to them leaves `cfgOut` unchanged but still counts toward the threshold.
- R8: Address 10 is reserved. A write to it changes no output slot but still counts toward the threshold.
- R9: Output slots are 4 bits each. Slot k occupies bits 4k+3:4k. Addresses 0 to 9 map to slots 0 to 9, address 11 to slot 10, address 12 to slot 11 and address 15 to slot 12.
- R10: The write counter saturates at the threshold. Any number of further writes leaves `unlocked` at 1.
- R11: A new reset closes the output stage again. The bank then needs another full threshold count of writes to unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Write strobe; a rising edge requests a write |
| wrAddr | input | 4 | Register address |
| wrData | input | 4 | Data nibble |
| cfgOut | output | 52 | Flat bus of 13 output slots, 4 bits each |
| unlocked | output | 1 | High once the output stage is transparent |

## Verification
The bench first writes every address, the absent and reserved ones included, with one data pattern. It then overwrites most of them with a second pattern, so that the values seen at unlock show the last write per address rather than the first. A strobe held high for five clocks falls inside the locked phase. That places the unlock exactly on the 32nd edge only if the long pulse counted once. After unlock, the bench writes a real address, the three addresses without outputs, and a long run of writes to a single address. These separate the immediate update from no update and show that the counter saturates. A second reset followed by a few writes checks that the output stage closes again.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
  localparam int ADDR_W   = 4;
  localparam int NIB_W    = 4;
  localparam int NUM_ADDR = 1 << ADDR_W;

  // Addresses that own an output slot: 0..9, 11, 12, 15
  localparam logic [NUM_ADDR-1:0] OUT_MASK = 16'b1001_1011_1111_1111;

  function automatic int countSet(input logic [NUM_ADDR-1:0] m, input int upto);
    int n;
    n = 0;
    for (int i = 0; i < NUM_ADDR; i++) begin
      if (i < upto && m[i]) n++;
    end
    return n;
  endfunction

  localparam int NUM_OUT = countSet(OUT_MASK, NUM_ADDR);
  localparam int OUT_W   = NUM_OUT * NIB_W;

  typedef struct packed {
    logic               latchOpen;
    logic [NUM_OUT-1:0] slotWr;
  } ctlStb_t;
endpackage

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
  import cfg_unlock_pkg::*;
#(
  parameter int UNLOCK_WRITES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctlStb_t           stb
);
  localparam int CNT_W = $clog2(UNLOCK_WRITES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(UNLOCK_WRITES);

  logic             stbPrev;
  logic             fire;
  logic [CNT_W-1:0] wrCnt;

  assign fire = wrStb & ~stbPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPrev <= 1'b0;
      wrCnt   <= '0;
    end else begin
      stbPrev <= wrStb;
      if (fire && (wrCnt != CNT_MAX)) wrCnt <= wrCnt + 1'b1;
    end
  end

  assign stb.latchOpen = (wrCnt == CNT_MAX);

  for (genvar a = 0; a < NUM_ADDR; a++) begin : gDec
    if (OUT_MASK[a]) begin : gReal
      localparam int SLOT = countSet(OUT_MASK, a);
      assign stb.slotWr[SLOT] = fire && (wrAddr == ADDR_W'(a));
    end
  end
endmodule

// File: rtl/cfg_unlock_dp.sv
module cfg_unlock_dp
  import cfg_unlock_pkg::*;
#(
  parameter logic [OUT_W-1:0] OUT_RST_VAL = '0
) (
  input  logic             clk,
  input  ctlStb_t          stb,
  input  logic [NIB_W-1:0] wrData,
  output logic [OUT_W-1:0] cfgOut
);
  for (genvar s = 0; s < NUM_OUT; s++) begin : gSlot
    logic [NIB_W-1:0] progReg;

    // Programming registers carry no reset on purpose
    always_ff @(posedge clk) begin
      if (stb.slotWr[s]) progReg <= wrData;
    end

    assign cfgOut[s*NIB_W +: NIB_W] =
      stb.latchOpen ? progReg : OUT_RST_VAL[s*NIB_W +: NIB_W];
  end
endmodule

// File: rtl/cfg_unlock_bank.sv
module cfg_unlock_bank
  import cfg_unlock_pkg::*;
#(
  parameter int               UNLOCK_WRITES = 32,
  parameter logic [OUT_W-1:0] OUT_RST_VAL   = 52'h0_1234_5678_9ABC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NIB_W-1:0]  wrData,
  output logic [OUT_W-1:0]  cfgOut,
  output logic              unlocked
);
  ctlStb_t stb;

  cfg_unlock_ctrl #(.UNLOCK_WRITES(UNLOCK_WRITES)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrStb  (wrStb),
    .wrAddr (wrAddr),
    .stb    (stb)
  );

  cfg_unlock_dp #(.OUT_RST_VAL(OUT_RST_VAL)) uDp (
    .clk    (clk),
    .stb    (stb),
    .wrData (wrData),
    .cfgOut (cfgOut)
  );

  assign unlocked = stb.latchOpen;
endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk
  import cfg_unlock_pkg::*;
#(
  parameter int               UNLOCK_WRITES = 32,
  parameter logic [OUT_W-1:0] OUT_RST_VAL   = 52'h0_1234_5678_9ABC
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [NIB_W-1:0]  wrData,
  input logic [OUT_W-1:0]  cfgOut,
  input logic              unlocked
);
  logic chkPrev;
  logic chkFire;
  int   chkCnt;

  assign chkFire = wrStb && !chkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkPrev <= 1'b0;
      chkCnt  <= 0;
    end else begin
      chkPrev <= wrStb;
      if (chkFire && chkCnt < UNLOCK_WRITES) chkCnt <= chkCnt + 1;
    end
  end

  // R1, R2
  a_r2_locked_reset_val: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> cfgOut == OUT_RST_VAL);

  // R3 (window checked with a counter)
  a_r3_unlock_on_count: assert property (@(posedge clk) disable iff (!rstN)
    unlocked == (chkCnt == UNLOCK_WRITES));

  a_r10_stays_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked);

  a_r5_immediate_slot0: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && chkFire && wrAddr == '0) |=> cfgOut[NIB_W-1:0] == $past(wrData));

  // R7, R8
  a_r7_no_output_addr: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && chkFire && !OUT_MASK[wrAddr]) |=> $stable(cfgOut));

  a_r6_hold_without_edge: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && !chkFire) |=> $stable(cfgOut));
endmodule

bind cfg_unlock_bank cfg_unlock_chk uChk (.*);

// File: tb/tb_cfg_unlock_bank.sv
module tb_cfg_unlock_bank;
  localparam int THRESH = 32;
  localparam logic [51:0] RST_VAL = 52'h0_1234_5678_9ABC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [3:0]  wrData = '0;
  logic [51:0] cfgOut;
  logic        unlocked;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;
  bit running = 0;

  // Reference model state
  int mProg[16];
  int mCnt = 0;
  bit mPrev = 0;
  int realAddr[13] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 11, 12, 15};

  cfg_unlock_bank dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr),
    .wrData(wrData), .cfgOut(cfgOut), .unlocked(unlocked)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0;
      mPrev = 0;
    end else begin
      if (wrStb && !mPrev) begin
        mProg[wrAddr] = int'(wrData);
        if (mCnt < THRESH) mCnt++;
      end
      mPrev = wrStb;
    end
  end

  function automatic bit expUnl();
    return rstN && (mCnt >= THRESH);
  endfunction

  function automatic logic [51:0] expOut();
    logic [51:0] v;
    v = RST_VAL;
    if (expUnl()) begin
      for (int k = 0; k < 13; k++) v[4*k +: 4] = mProg[realAddr[k]][3:0];
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (running) begin
      chk(unlocked == expUnl(), expUnl() ? "R3 status" : "R2 status",
          64'(unlocked), 64'(expUnl()));
      chk(cfgOut == expOut(), expUnl() ? "R5 outputs" : "R2 outputs",
          64'(cfgOut), 64'(expOut()));
    end
  end

  task automatic doWrite(input int a, input int d);
    @(negedge clk);
    wrAddr = 4'(a);
    wrData = 4'(d);
    wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog R3 act=timeout exp=done");
      finishRun();
    end
  end

  initial begin
    logic [51:0] snap;
    logic [51:0] want;
    running = 1;
    repeat (3) @(negedge clk);
    #3;
    chk(cfgOut == RST_VAL, "R1 reset value", 64'(cfgOut), 64'(RST_VAL));
    chk(unlocked == 1'b0, "R1 locked", 64'(unlocked), 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // Locked phase: first pattern over every address
    for (int a = 0; a < 16; a++) doWrite(a, (a * 3 + 1) & 15);
    #3;
    chk(cfgOut == RST_VAL, "R2 locked after 16 writes", 64'(cfgOut), 64'(RST_VAL));

    // R6: held strobe counts once
    @(negedge clk);
    wrAddr = 4'd1;
    wrData = 4'hE;
    wrStb = 1'b1;
    repeat (5) @(negedge clk);
    wrStb = 1'b0;

    // Second pattern, bringing the count to 31
    for (int a = 0; a < 14; a++) doWrite(a, 15 - a);
    #3;
    chk(unlocked == 1'b0, "R6 R3 still locked at 31", 64'(unlocked), 64'd0);

    doWrite(15, 6);
    #3;
    chk(unlocked == 1'b1, "R3 unlock on 32nd", 64'(unlocked), 64'd1);
    want = '0;
    for (int k = 0; k < 10; k++) want[4*k +: 4] = 4'(15 - k);
    want[43:40] = 4'd4;
    want[47:44] = 4'd3;
    want[51:48] = 4'd6;
    chk(cfgOut == want, "R4 values at unlock", 64'(cfgOut), 64'(want));
    chk(cfgOut[43:40] == 4'd4, "R9 addr 11 slot 10", 64'(cfgOut[43:40]), 64'd4);
    chk(cfgOut[51:48] == 4'd6, "R9 addr 15 slot 12", 64'(cfgOut[51:48]), 64'd6);

    doWrite(5, 10);
    #3;
    chk(cfgOut[23:20] == 4'hA, "R5 immediate write", 64'(cfgOut[23:20]), 64'hA);

    snap = cfgOut;
    doWrite(13, 15);
    doWrite(14, 15);
    #3;
    chk(cfgOut == snap, "R7 absent addresses", 64'(cfgOut), 64'(snap));
    doWrite(10, 15);
    #3;
    chk(cfgOut == snap, "R8 reserved address", 64'(cfgOut), 64'(snap));

    for (int i = 0; i < 40; i++) doWrite(12, i & 15);
    #3;
    chk(unlocked == 1'b1, "R10 saturated", 64'(unlocked), 64'd1);
    chk(cfgOut[47:44] == 4'd7, "R10 last write slot 11", 64'(cfgOut[47:44]), 64'd7);

    // R11: relock after a second reset
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    chk(unlocked == 1'b0, "R11 relocked", 64'(unlocked), 64'd0);
    chk(cfgOut == RST_VAL, "R11 reset value", 64'(cfgOut), 64'(RST_VAL));
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) doWrite(i, 9);
    #3;
    chk(cfgOut == RST_VAL && !unlocked, "R11 locked after 3 writes", 64'(cfgOut), 64'(RST_VAL));

    repeat (2) @(negedge clk);
    done = 1;
    finishRun();
  end
endmodule